// File: doc/BRIEF.md
# Lock-Aware Cache Victim Selector

This block decides, for one lookup in a set-associative cache, whether a miss may allocate a line and which way receives the fill. The tag pipeline presents the selected set's valid bits, its tree pseudo-LRU state, the hit result and two lock controls. One cycle later the block returns a registered decision: a hit, a fill into a named way, or a bypass in which the access is handled as cache-inhibited. It also returns the updated pseudo-LRU state for the set, which the caller writes back.

Two lock controls are supported. A whole-cache lock freezes the contents. Hits are still served, but misses never allocate, so invalid entries stay empty until the lock is released. A way-lock count protects a prefix of ways starting at way 0 from replacement. Invalid slots inside those locked ways may still be filled, and they are then kept. If both controls are set, the whole-cache lock wins.

Top module: `lock_victim_sel`

## Requirements
- R1: Each response is registered. `rsp_vld` is high exactly in the cycle after a cycle with `req_vld` high, and low otherwise. Synchronous reset drives every response output to 0.
- R2: On a hit (`req_hit`=1), the response has `rsp_alloc`=0, `rsp_inhibit`=0 and `rsp_way`=`req_hit_way`, whatever the lock controls are.
- R3: The pseudo-LRU state has WAYS-1 bits in heap order. Node n (root n=1, children 2n and 2n+1) sits at bit n-1. A node bit of 0 points the victim to its lower-numbered subtree and 1 to the higher one. A hit or a fill to way w sets every node on w's path to point away from w and leaves the other bits alone. For 4 ways, touching way 0 sets bits 0 and 1 to 1; way 1 sets bit 0=1, bit 1=0; way 2 sets bit 0=0, bit 2=1; way 3 sets bits 0 and 2 to 0.
- R4: A miss while `whole_lock`=1 gives `rsp_inhibit`=1, `rsp_alloc`=0, `rsp_way`=0, and `rsp_plru` equal to the request's state unchanged.
- R5: Invalid entries are never chosen while `whole_lock`=1. Once the lock is cleared, a miss into that set fills the invalid entry again.
- R6: A miss with `whole_lock`=0 and at least one invalid way allocates (`rsp_alloc`=1). It picks the lowest-numbered invalid way, even if that way lies inside the locked prefix.
- R7: `way_lock_cnt` (log2(WAYS) bits, so at most WAYS-1) locks ways 0 to count-1. A miss with every way valid and `whole_lock`=0 walks the tree and never enters a subtree made only of locked ways. The chosen way is always at or above the count.
- R8: With `way_lock_cnt`=0, a miss in a full set follows the plain tree pseudo-LRU walk.
- R9: With `whole_lock`=1 and a nonzero `way_lock_cnt`, a miss is still bypassed as in R4.
- R10: `rsp_alloc` and `rsp_inhibit` are never high together, and both are 0 when `rsp_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Lookup present this cycle |
| req_valid_bits | input | WAYS | Valid bit of each way in the addressed set |
| req_plru | input | WAYS-1 | Current tree pseudo-LRU state of the set |
| req_hit | input | 1 | Lookup hit |
| req_hit_way | input | log2(WAYS) | Way that hit |
| whole_lock | input | 1 | Freeze the entire cache |
| way_lock_cnt | input | log2(WAYS) | Number of locked ways counted from way 0 |
| rsp_vld | output | 1 | Response valid |
| rsp_alloc | output | 1 | Miss fills `rsp_way` |
| rsp_inhibit | output | 1 | Miss is bypassed as cache-inhibited |
| rsp_way | output | log2(WAYS) | Hit way or victim way |
| rsp_plru | output | WAYS-1 | Replacement state to write back |

## Verification
The bench builds the block with the default of four ways, so the lock count covers its whole legal range of 0 to 3. This reaches every case where the restricted walk differs from the plain one: a locked left half that forces the root right, a locked way 0 that forces way 1, and a locked way 2 that forces way 3. Four ways also make it possible to hand-check invalid-slot fills inside the locked prefix, whole-lock precedence over a nonzero count, and pseudo-LRU updates for each of the four ways.

// File: rtl/lvs_pkg.sv
package lvs_pkg;
  typedef enum logic [1:0] {
    OUT_NONE   = 2'd0,
    OUT_HIT    = 2'd1,
    OUT_FILL   = 2'd2,
    OUT_BYPASS = 2'd3
  } outcome_e;
endpackage

// File: rtl/lvs_first_invalid.sv
module lvs_first_invalid #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_bits[w]) begin
        found = 1'b1;
        idx   = w[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/lvs_tree_pick.sv
module lvs_tree_pick #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  plru,
  input  logic [IDX_W-1:0] lock_n,
  output logic [IDX_W-1:0] way
);
  always_comb begin
    int prefix;
    int node;
    int left_hi;
    logic dir;
    prefix = 0;
    for (int d = 0; d < IDX_W; d++) begin
      node    = (1 << d) | prefix;
      // highest way number under the lower-numbered child of this node
      left_hi = ((prefix << 1) << (IDX_W - d - 1)) | ((1 << (IDX_W - d - 1)) - 1);
      if (left_hi < int'(lock_n)) dir = 1'b1;
      else                        dir = plru[node-1];
      prefix  = (prefix << 1) | int'(dir);
    end
    way = prefix[IDX_W-1:0];
  end
endmodule

// File: rtl/lvs_tree_touch.sv
module lvs_tree_touch #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  plru_in,
  input  logic [IDX_W-1:0] way,
  output logic [WAYS-2:0]  plru_out
);
  always_comb begin
    int node;
    plru_out = plru_in;
    for (int d = 0; d < IDX_W; d++) begin
      node = (1 << d) | (int'(way) >> (IDX_W - d));
      plru_out[node-1] = ~way[IDX_W-1-d];
    end
  end
endmodule

// File: rtl/lock_victim_sel.sv
module lock_victim_sel #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_vld,
  input  logic [WAYS-1:0]  req_valid_bits,
  input  logic [WAYS-2:0]  req_plru,
  input  logic             req_hit,
  input  logic [IDX_W-1:0] req_hit_way,
  input  logic             whole_lock,
  input  logic [IDX_W-1:0] way_lock_cnt,
  output logic             rsp_vld,
  output logic             rsp_alloc,
  output logic             rsp_inhibit,
  output logic [IDX_W-1:0] rsp_way,
  output logic [WAYS-2:0]  rsp_plru
);
  import lvs_pkg::*;

  logic             inv_found;
  logic [IDX_W-1:0] inv_idx;
  logic [IDX_W-1:0] tree_way;
  logic [IDX_W-1:0] touch_way;
  logic [WAYS-2:0]  touched;
  outcome_e         outcome;
  logic [IDX_W-1:0] victim;

  lvs_first_invalid #(.WAYS(WAYS)) u_inv (
    .valid_bits (req_valid_bits),
    .found      (inv_found),
    .idx        (inv_idx)
  );

  lvs_tree_pick #(.WAYS(WAYS)) u_pick (
    .plru   (req_plru),
    .lock_n (way_lock_cnt),
    .way    (tree_way)
  );

  lvs_tree_touch #(.WAYS(WAYS)) u_touch (
    .plru_in  (req_plru),
    .way      (touch_way),
    .plru_out (touched)
  );

  always_comb begin
    victim = inv_found ? inv_idx : tree_way;
    if (!req_vld)        outcome = OUT_NONE;
    else if (req_hit)    outcome = OUT_HIT;
    else if (whole_lock) outcome = OUT_BYPASS;
    else                 outcome = OUT_FILL;
    touch_way = (outcome == OUT_HIT) ? req_hit_way : victim;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld     <= 1'b0;
      rsp_alloc   <= 1'b0;
      rsp_inhibit <= 1'b0;
      rsp_way     <= '0;
      rsp_plru    <= '0;
    end else begin
      rsp_vld     <= (outcome != OUT_NONE);
      rsp_alloc   <= (outcome == OUT_FILL);
      rsp_inhibit <= (outcome == OUT_BYPASS);
      case (outcome)
        OUT_HIT: begin
          rsp_way  <= req_hit_way;
          rsp_plru <= touched;
        end
        OUT_FILL: begin
          rsp_way  <= victim;
          rsp_plru <= touched;
        end
        OUT_BYPASS: begin
          rsp_way  <= '0;
          rsp_plru <= req_plru;
        end
        default: begin
          rsp_way  <= '0;
          rsp_plru <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lvs_checker.sv
module lvs_checker #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_vld,
  input logic [WAYS-1:0]  req_valid_bits,
  input logic [WAYS-2:0]  req_plru,
  input logic             req_hit,
  input logic [IDX_W-1:0] req_hit_way,
  input logic             whole_lock,
  input logic [IDX_W-1:0] way_lock_cnt,
  input logic             rsp_vld,
  input logic             rsp_alloc,
  input logic             rsp_inhibit,
  input logic [IDX_W-1:0] rsp_way,
  input logic [WAYS-2:0]  rsp_plru
);
  logic [WAYS-1:0]  vb_q;
  logic [IDX_W-1:0] lc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vb_q <= '1;
      lc_q <= '0;
    end else begin
      vb_q <= req_valid_bits;
      lc_q <= way_lock_cnt;
    end
  end

  assert_resp_timing_R1: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !rsp_vld);

  assert_hit_served_R2: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_hit) |=> (rsp_vld && !rsp_alloc && !rsp_inhibit
                              && rsp_way == $past(req_hit_way)));

  assert_bypass_R4: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !req_hit && whole_lock) |=> (rsp_inhibit && !rsp_alloc
                                             && rsp_plru == $past(req_plru)));

  assert_fill_invalid_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld && rsp_alloc && !(&vb_q)) |-> !vb_q[rsp_way]);

  assert_skip_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld && rsp_alloc && (&vb_q)) |-> (rsp_way >= lc_q));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(rsp_alloc && rsp_inhibit) && (rsp_vld || (!rsp_alloc && !rsp_inhibit)));
endmodule

bind lock_victim_sel lvs_checker #(.WAYS(WAYS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_vld        (req_vld),
  .req_valid_bits (req_valid_bits),
  .req_plru       (req_plru),
  .req_hit        (req_hit),
  .req_hit_way    (req_hit_way),
  .whole_lock     (whole_lock),
  .way_lock_cnt   (way_lock_cnt),
  .rsp_vld        (rsp_vld),
  .rsp_alloc      (rsp_alloc),
  .rsp_inhibit    (rsp_inhibit),
  .rsp_way        (rsp_way),
  .rsp_plru       (rsp_plru)
);

// File: tb/lock_victim_sel_bench.sv
module lock_victim_sel_bench;
  localparam int WAYS = 4;
  localparam int NV = 17;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_vld = 1'b0;
  logic [3:0] req_valid_bits = 4'hF;
  logic [2:0] req_plru = '0;
  logic       req_hit = 1'b0;
  logic [1:0] req_hit_way = '0;
  logic       whole_lock = 1'b0;
  logic [1:0] way_lock_cnt = '0;
  logic       rsp_vld, rsp_alloc, rsp_inhibit;
  logic [1:0] rsp_way;
  logic [2:0] rsp_plru;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  lock_victim_sel #(.WAYS(WAYS)) u_lock_victim_sel (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_valid_bits(req_valid_bits),
    .req_plru(req_plru), .req_hit(req_hit), .req_hit_way(req_hit_way),
    .whole_lock(whole_lock), .way_lock_cnt(way_lock_cnt), .rsp_vld(rsp_vld),
    .rsp_alloc(rsp_alloc), .rsp_inhibit(rsp_inhibit), .rsp_way(rsp_way),
    .rsp_plru(rsp_plru)
  );

  // {whole, cnt[2], hit, hway[2], valid[4], plru[3] | alloc, inhibit, way[2], plru_out[3]}
  localparam logic [19:0] VEC [NV] = '{
    20'b0_00_1_10_1111_000__0_0_10_100, // R2 R3 hit way2
    20'b1_00_1_01_1111_000__0_0_01_001, // R2 hit under whole lock
    20'b1_00_0_00_0111_101__0_1_00_101, // R4 R5 miss, whole lock, invalid way3 kept
    20'b0_00_0_00_0111_101__1_0_11_000, // R5 R6 lock cleared, way3 filled
    20'b0_10_0_00_1110_000__1_0_00_011, // R6 invalid slot inside locked prefix
    20'b0_00_0_00_1111_000__1_0_00_011, // R8 plain walk
    20'b0_01_0_00_1111_000__1_0_01_001, // R7 way0 locked
    20'b0_10_0_00_1111_000__1_0_10_100, // R7 left half locked
    20'b0_11_0_00_1111_000__1_0_11_000, // R7 three locked
    20'b0_11_0_00_1111_111__1_0_11_010, // R7 three locked, other state
    20'b0_00_0_00_1111_111__1_0_11_010, // R8 plain walk to way3
    20'b0_01_0_00_1111_010__1_0_01_001, // R7 one locked
    20'b0_00_0_00_1111_011__1_0_10_110, // R8 R3 plain walk to way2
    20'b1_10_0_00_1111_011__0_1_00_011, // R9 whole lock beats count
    20'b0_11_1_00_1111_000__0_0_00_011, // R2 hit in a locked way
    20'b0_11_0_00_0000_100__1_0_00_111, // R6 all invalid, all but one locked
    20'b0_01_0_00_1111_001__1_0_10_100  // R7 root points right
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [12:0] f);
    req_vld        = 1'b1;
    whole_lock     = f[12];
    way_lock_cnt   = f[11:10];
    req_hit        = f[9];
    req_hit_way    = f[8:7];
    req_valid_bits = f[6:3];
    req_plru       = f[2:0];
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset vld", int'(rsp_vld), 0);
    chk("R1 reset alloc/inhibit", int'({rsp_alloc, rsp_inhibit}), 0);
    chk("R1 reset way/plru", int'({rsp_way, rsp_plru}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle no response", int'(rsp_vld), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19:7]);
      @(negedge clk);
      chk($sformatf("R1 vec%0d vld", i), int'(rsp_vld), 1);
      chk($sformatf("R10 vec%0d alloc", i), int'(rsp_alloc), int'(VEC[i][6]));
      chk($sformatf("R4 vec%0d inhibit", i), int'(rsp_inhibit), int'(VEC[i][5]));
      chk($sformatf("R7 vec%0d way", i), int'(rsp_way), int'(VEC[i][4:3]));
      chk($sformatf("R3 vec%0d plru", i), int'(rsp_plru), int'(VEC[i][2:0]));
    end

    // R1: a gap after requests gives no response
    req_vld = 1'b0;
    @(negedge clk);
    chk("R1 gap no response", int'(rsp_vld), 0);
    chk("R10 gap flags low", int'({rsp_alloc, rsp_inhibit}), 0);

    // R5: repeated misses under whole lock never fill the empty ways
    for (int k = 0; k < 4; k++) begin
      drive({1'b1, 2'd0, 1'b0, 2'd0, 4'b0101, 3'(k)});
      @(negedge clk);
      chk("R5 locked miss no fill", int'(rsp_alloc), 0);
      chk("R5 locked miss bypass", int'(rsp_inhibit), 1);
    end
    drive({1'b0, 2'd0, 1'b0, 2'd0, 4'b0101, 3'd0});
    @(negedge clk);
    chk("R5 released fill", int'(rsp_alloc), 1);
    chk("R5 released lowest invalid", int'(rsp_way), 1);

    // R1: reset mid-stream clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-run", int'({rsp_vld, rsp_alloc, rsp_inhibit}), 0);
    rst = 1'b0;
    req_vld = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule